// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the memory operand address for a core with 16-bit general registers and byte or word operands. It takes the decoded addressing mode, the operand size, the value of the selected base register, the instruction's 16-bit extension word and its 8-bit short absolute field. From these it produces the effective address and a flag saying that the address is valid.

For the two auto-modify modes it also produces the new value to write back to the base register, together with a write enable. It raises an alignment error when a word operand would land on an odd address.

Fetch, decode, the register file and the memory bus sit outside the block. By default one register stage follows the arithmetic, so all outputs appear together one clock after the inputs. A parameter removes that stage and makes the block purely combinational.

Top module: `opnd_addr_gen`

## Requirements
- R1: Mode code 0 (register operand) gives addr_vld_o=0, wb_en_o=0, addr_o=0, wb_val_o=0 and align_err_o=0, whatever the size or base value.
- R2: Mode code 1 (indirect) gives addr_o = base_i with addr_vld_o=1 and no write-back (wb_en_o=0, wb_val_o=0).
- R3: Mode code 2 (displacement) gives addr_o = base_i + ext_i with addr_vld_o=1 and no write-back.
- R4: Mode code 5 (short absolute) gives addr_o = {8'hFF, short_i}, so the address always lies in 0xFF00 to 0xFFFF. The value of base_i has no effect.
- R5: Mode code 6 (long absolute) gives addr_o = ext_i with addr_vld_o=1 and no write-back.
- R6: Mode code 3 (post-increment) gives addr_o = base_i, wb_en_o=1 and wb_val_o = base_i + step. The step is 1 when size_i=0 (byte) and 2 when size_i=1 (word).
- R7: Mode code 4 (pre-decrement) gives addr_o = base_i - step and wb_en_o=1, with wb_val_o equal to that same address. The step is the same as in R6.
- R8: All address and write-back arithmetic wraps modulo 2^16. For example, 0x0000 - 1 = 0xFFFF and 0xFFFE + 2 = 0x0000.
- R9: align_err_o is 1 exactly when size_i=1 (word), addr_vld_o=1 and addr_o is odd. For the auto-modify modes this is the same as an odd base_i. A byte operand never raises it.
- R10: With OUT_REG=1 (the default), every output changes one rising clock edge after its inputs, and all outputs are 0 while rst_ni is low. With OUT_REG=0 the outputs follow the inputs combinationally.
- R11: Mode code 7 is reserved and behaves exactly like mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Addressing mode code (0..7) |
| size_i | input | 1 | Operand size: 0 byte, 1 word |
| base_i | input | 16 | Value of the selected base register |
| ext_i | input | 16 | Displacement or long absolute extension word |
| short_i | input | 8 | Short absolute field |
| addr_o | output | 16 | Effective address |
| addr_vld_o | output | 1 | Effective address is valid (memory operand) |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_val_o | output | 16 | New base register value |
| align_err_o | output | 1 | Word access on an odd address |

## Verification
The block holds no state apart from the output stage. A fault in the arithmetic or in the mode decode therefore shows up on the outputs at the very next edge, as a wrong address, a missing write-back or a misplaced alignment flag. The corner values are chosen so that an error in the step size, a carry or borrow lost at the 16-bit boundary, or an ignored forcing of the upper page would each change a specific output bit. A fault in the output stage shows as an output that appears one cycle early or late, or that does not clear during reset.

// File: rtl/oag_pkg.sv
package oag_pkg;
  typedef enum logic [2:0] {
    AM_REG   = 3'd0,
    AM_IND   = 3'd1,
    AM_DISP  = 3'd2,
    AM_POST  = 3'd3,
    AM_PRE   = 3'd4,
    AM_ABS8  = 3'd5,
    AM_ABS16 = 3'd6,
    AM_RSVD  = 3'd7
  } amode_e;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } osize_e;
endpackage

// File: rtl/oag_addr_calc.sv
module oag_addr_calc import oag_pkg::*; #(
  parameter int unsigned AW = 16,
  parameter int unsigned SW = 8
) (
  input  logic [2:0]    mode_i,
  input  logic          size_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ext_i,
  input  logic [SW-1:0] short_i,
  output logic [AW-1:0] addr_o,
  output logic          vld_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o
);
  localparam int unsigned PAGE_W = AW - SW;

  logic [AW-1:0] step;
  logic [AW-1:0] inc_val;
  logic [AW-1:0] dec_val;
  logic [AW-1:0] disp_sum;
  logic [AW-1:0] page_addr;

  // step is 1 for byte, 2 for word
  assign step      = {{(AW-2){1'b0}}, size_i, ~size_i};
  assign inc_val   = base_i + step;
  assign dec_val   = base_i - step;
  assign disp_sum  = base_i + ext_i;
  assign page_addr = {{PAGE_W{1'b1}}, short_i};

  always_comb begin
    addr_o   = '0;
    vld_o    = 1'b0;
    wb_en_o  = 1'b0;
    wb_val_o = '0;
    case (amode_e'(mode_i))
      AM_IND: begin
        addr_o = base_i;
        vld_o  = 1'b1;
      end
      AM_DISP: begin
        addr_o = disp_sum;
        vld_o  = 1'b1;
      end
      AM_POST: begin
        addr_o   = base_i;
        vld_o    = 1'b1;
        wb_en_o  = 1'b1;
        wb_val_o = inc_val;
      end
      AM_PRE: begin
        addr_o   = dec_val;
        vld_o    = 1'b1;
        wb_en_o  = 1'b1;
        wb_val_o = dec_val;
      end
      AM_ABS8: begin
        addr_o = page_addr;
        vld_o  = 1'b1;
      end
      AM_ABS16: begin
        addr_o = ext_i;
        vld_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/oag_align_chk.sv
module oag_align_chk import oag_pkg::*; #(
  parameter int unsigned AW = 16
) (
  input  logic          size_i,
  input  logic          vld_i,
  input  logic [AW-1:0] addr_i,
  output logic          err_o
);
  // pre-dec with even step keeps parity, so checking the address covers the base
  assign err_o = vld_i && (osize_e'(size_i) == SZ_WORD) && addr_i[0];
endmodule

// File: rtl/oag_out_stage.sv
module oag_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (OUT_REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= '0;
        else         q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_comb
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen import oag_pkg::*; #(
  parameter int unsigned AW      = 16,
  parameter int unsigned SW      = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          size_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ext_i,
  input  logic [SW-1:0] short_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_vld_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o,
  output logic          align_err_o
);
  localparam int unsigned PKT_W = 2*AW + 3;

  logic [AW-1:0]    c_addr;
  logic             c_vld;
  logic             c_wb_en;
  logic [AW-1:0]    c_wb_val;
  logic             c_err;
  logic [PKT_W-1:0] pkt_d;
  logic [PKT_W-1:0] pkt_q;

  oag_addr_calc #(.AW(AW), .SW(SW)) u_calc (
    .mode_i  (mode_i),
    .size_i  (size_i),
    .base_i  (base_i),
    .ext_i   (ext_i),
    .short_i (short_i),
    .addr_o  (c_addr),
    .vld_o   (c_vld),
    .wb_en_o (c_wb_en),
    .wb_val_o(c_wb_val)
  );

  oag_align_chk #(.AW(AW)) u_align (
    .size_i(size_i),
    .vld_i (c_vld),
    .addr_i(c_addr),
    .err_o (c_err)
  );

  assign pkt_d = {c_addr, c_vld, c_wb_en, c_wb_val, c_err};

  oag_out_stage #(.W(PKT_W), .OUT_REG(OUT_REG)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pkt_d),
    .q_o   (pkt_q)
  );

  assign {addr_o, addr_vld_o, wb_en_o, wb_val_o, align_err_o} = pkt_q;
endmodule

// File: rtl/oag_chk.sv
module oag_chk #(
  parameter int unsigned AW      = 16,
  parameter int unsigned SW      = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    mode_i,
  input logic          size_i,
  input logic [AW-1:0] base_i,
  input logic [AW-1:0] ext_i,
  input logic [SW-1:0] short_i,
  input logic [AW-1:0] addr_o,
  input logic          addr_vld_o,
  input logic          wb_en_o,
  input logic [AW-1:0] wb_val_o,
  input logic          align_err_o
);
  logic [2:0]    m;
  logic          sz;
  logic [AW-1:0] b;
  logic [AW-1:0] e;
  logic [SW-1:0] s;
  logic [AW-1:0] stp;

  generate
    if (OUT_REG) begin : g_dly
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          m <= '0; sz <= 1'b0; b <= '0; e <= '0; s <= '0;
        end else begin
          m <= mode_i; sz <= size_i; b <= base_i; e <= ext_i; s <= short_i;
        end
      end
    end else begin : g_now
      assign m = mode_i;
      assign sz = size_i;
      assign b = base_i;
      assign e = ext_i;
      assign s = short_i;
    end
  endgenerate

  assign stp = sz ? AW'(2) : AW'(1);

  AST_REG_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m == 3'd0 || m == 3'd7) |-> (!addr_vld_o && !wb_en_o && !align_err_o)); // R1
  AST_IND_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m == 3'd1) |-> (addr_vld_o && addr_o == b && !wb_en_o)); // R2
  AST_DISP_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m == 3'd2) |-> (addr_vld_o && addr_o == AW'(b + e))); // R3
  AST_SHORT_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m == 3'd5) |-> (addr_o[AW-1:SW] == '1 && addr_o[SW-1:0] == s)); // R4
  AST_LONG_ABS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m == 3'd6) |-> (addr_o == e && !wb_en_o)); // R5
  AST_POST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m == 3'd3) |-> (addr_o == b && wb_en_o && wb_val_o == AW'(b + stp))); // R6
  AST_PRE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m == 3'd4) |-> (wb_en_o && addr_o == wb_val_o && wb_val_o == AW'(b - stp))); // R7
  AST_WB_ONLY_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (m == 3'd3 || m == 3'd4)); // R6
  AST_ALIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o == (sz && addr_vld_o && addr_o[0])); // R9
endmodule

bind opnd_addr_gen oag_chk #(.AW(AW), .SW(SW), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_opnd_addr_gen.sv
module sim_opnd_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = 3'd6;
  logic        size_i = 1'b0;
  logic [15:0] base_i = 16'h0;
  logic [15:0] ext_i = 16'h1234;
  logic [7:0]  short_i = 8'h0;
  logic [15:0] addr_o;
  logic        addr_vld_o;
  logic        wb_en_o;
  logic [15:0] wb_val_o;
  logic        align_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] addr;
    logic        vld;
    logic        wb;
    logic [15:0] wbv;
    logic        err;
    string       req;
  } exp_t;

  exp_t q[$];

  always #5 clk_i = ~clk_i;

  opnd_addr_gen u0 (.*);

  function automatic exp_t model(input logic [2:0] m, input logic sz,
                                 input logic [15:0] b, input logic [15:0] e,
                                 input logic [7:0] s, input string req);
    exp_t x;
    logic [15:0] st;
    st = sz ? 16'd2 : 16'd1;
    x.addr = 16'h0; x.vld = 1'b0; x.wb = 1'b0; x.wbv = 16'h0; x.req = req;
    case (m)
      3'd1: begin x.addr = b; x.vld = 1'b1; end
      3'd2: begin x.addr = b + e; x.vld = 1'b1; end
      3'd3: begin x.addr = b; x.vld = 1'b1; x.wb = 1'b1; x.wbv = b + st; end
      3'd4: begin x.addr = b - st; x.vld = 1'b1; x.wb = 1'b1; x.wbv = b - st; end
      3'd5: begin x.addr = {8'hFF, s}; x.vld = 1'b1; end
      3'd6: begin x.addr = e; x.vld = 1'b1; end
      default: ;
    endcase
    x.err = sz && x.vld && x.addr[0];
    return x;
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drv(input logic [2:0] m, input logic sz, input logic [15:0] b,
                     input logic [15:0] e, input logic [7:0] s, input string req);
    @(negedge clk_i);
    mode_i = m; size_i = sz; base_i = b; ext_i = e; short_i = s;
    q.push_back(model(m, sz, b, e, s, req));
  endtask

  // monitor: registered outputs settle just after the rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        chk(x.req, "addr", addr_o, x.addr);
        chk(x.req, "vld", 16'(addr_vld_o), 16'(x.vld));
        chk(x.req, "wb_en", 16'(wb_en_o), 16'(x.wb));
        chk(x.req, "wb_val", wb_val_o, x.wbv);
        chk(x.req, "align", 16'(align_err_o), 16'(x.err));
      end
    end
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    // R10: reset clears outputs even with a valid mode on the inputs
    repeat (3) @(posedge clk_i);
    #2;
    chk("R10", "rst addr", addr_o, 16'h0);
    chk("R10", "rst vld", 16'(addr_vld_o), 16'h0);
    chk("R10", "rst wb", 16'(wb_en_o), 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mode_i = 3'd0;

    // R1, R11
    drv(3'd0, 1'b1, 16'h1235, 16'hAAAA, 8'h55, "R1");
    drv(3'd0, 1'b0, 16'hFFFF, 16'h0001, 8'hFF, "R1");
    drv(3'd7, 1'b1, 16'h4001, 16'h1111, 8'h12, "R11");
    // R2, R9
    drv(3'd1, 1'b0, 16'h4001, 16'h0, 8'h0, "R2");
    drv(3'd1, 1'b1, 16'h4000, 16'h0, 8'h0, "R2");
    drv(3'd1, 1'b1, 16'h4001, 16'h0, 8'h0, "R9");
    // R3, R8
    drv(3'd2, 1'b1, 16'h1000, 16'h0234, 8'h0, "R3");
    drv(3'd2, 1'b0, 16'h1000, 16'hF001, 8'h0, "R3");
    drv(3'd2, 1'b0, 16'hFFF0, 16'h0020, 8'h0, "R8");
    // R4: base is irrelevant
    drv(3'd5, 1'b0, 16'h1234, 16'h0, 8'h5A, "R4");
    drv(3'd5, 1'b0, 16'hFFFF, 16'h0, 8'h00, "R4");
    drv(3'd5, 1'b1, 16'h0000, 16'h0, 8'hFF, "R4");
    // R5
    drv(3'd6, 1'b1, 16'h1111, 16'h8ACE, 8'h77, "R5");
    drv(3'd6, 1'b0, 16'h0, 16'h0001, 8'h0, "R5");
    // R6
    drv(3'd3, 1'b0, 16'h2000, 16'h0, 8'h0, "R6");
    drv(3'd3, 1'b1, 16'h2000, 16'h0, 8'h0, "R6");
    drv(3'd3, 1'b1, 16'hFFFE, 16'h0, 8'h0, "R8");
    drv(3'd3, 1'b0, 16'hFFFF, 16'h0, 8'h0, "R8");
    drv(3'd3, 1'b1, 16'h2001, 16'h0, 8'h0, "R9");
    // R7
    drv(3'd4, 1'b0, 16'h3000, 16'h0, 8'h0, "R7");
    drv(3'd4, 1'b1, 16'h3000, 16'h0, 8'h0, "R7");
    drv(3'd4, 1'b0, 16'h0000, 16'h0, 8'h0, "R8");
    drv(3'd4, 1'b1, 16'h0000, 16'h0, 8'h0, "R8");
    drv(3'd4, 1'b1, 16'h3001, 16'h0, 8'h0, "R9");
    drv(3'd4, 1'b0, 16'h3001, 16'h0, 8'h0, "R9");

    // R10: output holds the previous result until the next rising edge
    @(posedge clk_i);
    #2;
    @(negedge clk_i);
    mode_i = 3'd6; size_i = 1'b0; ext_i = 16'hBEEF;
    #1;
    chk("R10", "latency hold", addr_o, 16'h3000);
    @(posedge clk_i);
    #2;
    chk("R10", "latency update", addr_o, 16'hBEEF);

    repeat (3) @(posedge clk_i);
    #3;
    chk("R10", "queue drained", 16'(q.size()), 16'h0);
    done = 1'b1;
    finish_sim();
  end
endmodule